// File: doc/BRIEF.md
# Multi-channel DMA descriptor intake

This block is the register-side entry point of a DMA engine with up to sixteen channels. Software loads a source address, a destination address and a size word into three shared staging registers. It then writes a channel number to a commit register. That commit write alone copies the staged triple into the chosen channel's four-entry queue. The staging registers keep their contents afterwards, so a refused commit can be repeated without loading them again. A consumer port on the engine side takes descriptors out one channel at a time. A completion port tells the block when the descriptor in flight on a channel has finished.

Each channel has a control word. It holds the enable bit, the queue-full flag, the number of queued descriptors and a 4-bit watermark. Per-channel sticky event bits are kept for finished descriptors, drained queues, watermark crossings and refused commits. A summary word gives the lowest disabled channel and a bitmap of enabled channels.

Register word addresses are as follows:
- 0x00, 0x01 and 0x02: staging source, destination and size.
- 0x03: commit.
- Event registers:

  | Event | Status | Clear | Set |
  |---|---|---|---|
  | Completion | 0x04 | 0x05 | 0x06 |
  | Drain | 0x07 | 0x08 | 0x09 |
  | Watermark | 0x0A | 0x0B | 0x0C |

- 0x0D: overflow status. Writing 1 to a bit clears it.
- 0x0E: summary word.
- 0x10 + n: control word of channel n.

Top module: `dma_desc_intake`

## Requirements
- R1: A write of a value below NCH to 0x03 appends the current staging triple to that channel's queue. A pop on an enabled channel drives pop_vld high in the same cycle, together with that channel's oldest descriptor. Queues are first in, first out.
- R2: In control word n, bit 17 reads 1 exactly when four descriptors are queued. Bits 25:20 give the queued count. Bit 0 is the enable bit. Bits 29:26 hold the watermark, and a control write loads them from the written data.
- R3: A commit to a full channel is dropped and sets bit n of 0x0D. The staging registers keep their values, so the same commit succeeds once space frees up.
- R4: A commit write with a value of NCH or more changes no queue.
- R5: The watermark bit of a channel sets when a pop, with no commit to that channel in the same cycle, takes the count from the watermark value to one below it. A watermark of 0 never fires.
- R6: The drain bit of a channel sets when a pop, with no commit to that channel in the same cycle, takes its count from 1 to 0.
- R7: The completion bit of a channel sets when the completion port names that channel while a descriptor is in flight on it. A completion on an idle channel is ignored.
- R8: Event bits are sticky. Writing 1 to a bit of the clear register clears that bit, and writing 1 to a bit of the set register forces it. A hardware event in the same cycle as a clear wins.
- R9: A pop is accepted only when the channel is enabled, has no descriptor in flight, has no disable pending and has a non-empty queue. An accepted pop leaves one descriptor in flight until completion.
- R10: Writing bit 0 = 0 to an enabled channel's control word leaves bit 0 reading 1 while a descriptor is in flight. Bit 0 reads 0 from the second cycle after the channel becomes idle. Writing bit 0 = 1 re-enables the channel and cancels a pending disable.
- R11: When a descriptor whose size word has bit 24 set completes, the channel's enable bit reads 0 from the next cycle.
- R12: At 0x0E, bits 4:0 hold the lowest channel number whose enable is 0, or NCH when all channels are enabled. Bits 31:16 hold the enable bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | 32 | Combinational read data |
| pop_req | input | 1 | Consumer pop request |
| pop_ch | input | CW | Channel to pop |
| pop_vld | output | 1 | Pop accepted, descriptor outputs valid |
| pop_src | output | 32 | Popped source address |
| pop_dst | output | 32 | Popped destination address |
| pop_size | output | 32 | Popped size word |
| cmpl_vld | input | 1 | Completion strobe |
| cmpl_ch | input | CW | Channel whose descriptor finished |

## Verification
The bench targets several timing corner cases:
- A commit and a pop on the same channel in the same cycle. A design that counted both edges independently would raise a spurious drain or watermark bit.
- A commit to a full queue. A design that wrapped the write pointer would overwrite the oldest descriptor instead of flagging overflow.
- A disable written while a descriptor is in flight. A design that cleared the enable bit at once would let a poller believe the channel had stopped early.
- A clear that lands in the same cycle as a hardware event. A design that gave the clear priority would lose that event.

The summary word is read with no channel enabled, with some enabled and with all enabled. An error in the priority search, or in the out-of-range value returned when every channel is enabled, shows up as a wrong field.

// File: rtl/dma_desc_intake.sv
module dma_desc_intake #(
  parameter int NCH = 16,
  parameter int DEPTH = 4,
  parameter int AW = 8,
  parameter int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          pop_req,
  input  logic [CW-1:0] pop_ch,
  output logic          pop_vld,
  output logic [31:0]   pop_src,
  output logic [31:0]   pop_dst,
  output logic [31:0]   pop_size,
  input  logic          cmpl_vld,
  input  logic [CW-1:0] cmpl_ch
);
  localparam int PW = $clog2(DEPTH);
  localparam int AD_BIT = 24;
  localparam logic [AW-1:0] A_SRC = 0, A_DST = 1, A_SIZE = 2, A_PUSH = 3;
  localparam logic [AW-1:0] A_TC = 4, A_TCC = 5, A_TCS = 6;
  localparam logic [AW-1:0] A_PC = 7, A_PCC = 8, A_PCS = 9;
  localparam logic [AW-1:0] A_LW = 10, A_LWC = 11, A_LWS = 12;
  localparam logic [AW-1:0] A_OVF = 13, A_NF = 14, A_CTL = 16;

  logic [31:0]   stg_src, stg_dst, stg_size;
  logic [31:0]   q_src  [NCH][DEPTH];
  logic [31:0]   q_dst  [NCH][DEPTH];
  logic [31:0]   q_size [NCH][DEPTH];
  logic [PW-1:0] wp [NCH];
  logic [PW-1:0] rp [NCH];
  logic [PW:0]   cnt [NCH];
  logic [3:0]    wm [NCH];
  logic [NCH-1:0] en, stop, busy, ad, full, tc_st, pc_st, lw_st, ovf_st;
  logic [NCH-1:0] psh, psh_ok, pp, cm, cw;
  logic [4:0]    nf;

  wire push = wr_en && wr_addr == A_PUSH && wr_data < 32'(NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign full[i]   = cnt[i] == (PW+1)'(DEPTH);
    assign psh[i]    = push && wr_data[CW-1:0] == CW'(i);
    assign psh_ok[i] = psh[i] && !full[i];
    assign pp[i]     = pop_req && pop_ch == CW'(i) && en[i] && !busy[i] && !stop[i] && cnt[i] != '0;
    assign cm[i]     = cmpl_vld && cmpl_ch == CW'(i) && busy[i];
    assign cw[i]     = wr_en && wr_addr == A_CTL + AW'(i);
  end

  assign pop_vld  = |pp;
  assign pop_src  = q_src[pop_ch][rp[pop_ch]];
  assign pop_dst  = q_dst[pop_ch][rp[pop_ch]];
  assign pop_size = q_size[pop_ch][rp[pop_ch]];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++)
      if (psh_ok[i]) begin
        q_src[i][wp[i]]  <= stg_src;
        q_dst[i][wp[i]]  <= stg_dst;
        q_size[i][wp[i]] <= stg_size;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_src <= '0; stg_dst <= '0; stg_size <= '0;
      en <= '0; stop <= '0; busy <= '0; ad <= '0;
      tc_st <= '0; pc_st <= '0; lw_st <= '0; ovf_st <= '0;
      for (int i = 0; i < NCH; i++) begin
        wp[i] <= '0; rp[i] <= '0; cnt[i] <= '0; wm[i] <= '0;
      end
    end else begin
      if (wr_en)
        case (wr_addr)
          A_SRC:  stg_src  <= wr_data;
          A_DST:  stg_dst  <= wr_data;
          A_SIZE: stg_size <= wr_data;
          A_TCC:  tc_st  <= tc_st  & ~wr_data[NCH-1:0];
          A_TCS:  tc_st  <= tc_st  |  wr_data[NCH-1:0];
          A_PCC:  pc_st  <= pc_st  & ~wr_data[NCH-1:0];
          A_PCS:  pc_st  <= pc_st  |  wr_data[NCH-1:0];
          A_LWC:  lw_st  <= lw_st  & ~wr_data[NCH-1:0];
          A_LWS:  lw_st  <= lw_st  |  wr_data[NCH-1:0];
          A_OVF:  ovf_st <= ovf_st & ~wr_data[NCH-1:0];
          default: ;
        endcase
      for (int i = 0; i < NCH; i++) begin
        if (stop[i] && !busy[i]) begin
          en[i] <= 1'b0;
          stop[i] <= 1'b0;
        end
        if (pp[i]) begin
          rp[i]   <= rp[i] + 1'b1;
          busy[i] <= 1'b1;
          ad[i]   <= q_size[i][rp[i]][AD_BIT];
          if (!psh_ok[i] && cnt[i] == (PW+1)'(1)) pc_st[i] <= 1'b1;
          if (!psh_ok[i] && wm[i] != '0 && 32'(cnt[i]) == 32'(wm[i])) lw_st[i] <= 1'b1;
        end
        if (psh_ok[i]) wp[i] <= wp[i] + 1'b1;
        cnt[i] <= cnt[i] + (PW+1)'(psh_ok[i]) - (PW+1)'(pp[i]);
        if (cm[i]) begin
          busy[i]  <= 1'b0;
          tc_st[i] <= 1'b1;
          if (ad[i]) begin
            en[i] <= 1'b0;
            stop[i] <= 1'b0;
          end
        end
        if (cw[i]) begin
          wm[i] <= wr_data[29:26];
          if (wr_data[0]) begin
            en[i] <= 1'b1;
            stop[i] <= 1'b0;
          end else if (en[i]) stop[i] <= 1'b1;
        end
        if (psh[i] && full[i]) ovf_st[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    nf = 5'(NCH);
    for (int i = NCH - 1; i >= 0; i--)
      if (!en[i]) nf = 5'(i);
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SRC:  rd_data = stg_src;
      A_DST:  rd_data = stg_dst;
      A_SIZE: rd_data = stg_size;
      A_TC:   rd_data = 32'(tc_st);
      A_PC:   rd_data = 32'(pc_st);
      A_LW:   rd_data = 32'(lw_st);
      A_OVF:  rd_data = 32'(ovf_st);
      A_NF:   rd_data = {16'(en), 11'b0, nf};
      default:
        if (rd_addr >= A_CTL && rd_addr < A_CTL + AW'(NCH))
          rd_data = {2'b0, wm[rd_addr[CW-1:0]], 6'(cnt[rd_addr[CW-1:0]]), 2'b0,
                     full[rd_addr[CW-1:0]], 16'b0, en[rd_addr[CW-1:0]]};
    endcase
  end
endmodule

// File: rtl/dma_desc_intake_chk.sv
module dma_desc_intake_chk #(
  parameter int NCH = 16,
  parameter int AW = 8,
  parameter int CW = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic          pop_vld,
  input logic [CW-1:0] pop_ch,
  input logic          cmpl_vld,
  input logic [CW-1:0] cmpl_ch,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] full,
  input logic [NCH-1:0] tc_st,
  input logic [NCH-1:0] ovf_st
);
  localparam logic [AW-1:0] C_PUSH = 3, C_TCC = 5;

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == C_PUSH && wr_data < 32'(NCH) && full[wr_data[CW-1:0]])
    |=> ovf_st[$past(wr_data[CW-1:0])]);

  // R9
  pop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld |=> busy[$past(pop_ch)]);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[i] && !(cmpl_vld && cmpl_ch == CW'(i))) |=> busy[i]);
    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && busy[i] && !(cmpl_vld && cmpl_ch == CW'(i))) |=> en[i]);
    // R8
    tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_st[i] && !(wr_en && wr_addr == C_TCC && wr_data[i])) |=> tc_st[i]);
  end
endmodule

bind dma_desc_intake dma_desc_intake_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_dma_desc_intake.sv
`timescale 1ns/1ps
module sim_dma_desc_intake;
  localparam int NCH = 16;
  logic clk = 0, rst_n = 0;
  logic d_wr_en = 0, d_pop_req = 0, d_cmpl_vld = 0;
  logic [7:0] d_wr_addr = 0, d_rd_addr = 0;
  logic [31:0] d_wr_data = 0;
  logic [3:0] d_pop_ch = 0, d_cmpl_ch = 0;
  logic [31:0] rd_data, pop_src, pop_dst, pop_size;
  logic pop_vld;
  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  dma_desc_intake u0 (.clk, .rst_n, .wr_en(d_wr_en), .wr_addr(d_wr_addr), .wr_data(d_wr_data),
    .rd_addr(d_rd_addr), .rd_data, .pop_req(d_pop_req), .pop_ch(d_pop_ch), .pop_vld,
    .pop_src, .pop_dst, .pop_size, .cmpl_vld(d_cmpl_vld), .cmpl_ch(d_cmpl_ch));

  bit [95:0] mq[NCH][$];
  bit [NCH-1:0] m_en, m_stop, m_busy, m_ad, m_tc, m_pc, m_lw, m_ovf;
  bit [3:0] m_wm[NCH];
  bit [31:0] m_src, m_dst, m_size;

  function automatic logic [31:0] m_read(logic [7:0] a);
    int k;
    case (a)
      0: return m_src;
      1: return m_dst;
      2: return m_size;
      4: return 32'(m_tc);
      7: return 32'(m_pc);
      10: return 32'(m_lw);
      13: return 32'(m_ovf);
      14: begin
        k = NCH;
        for (int i = NCH - 1; i >= 0; i--) if (!m_en[i]) k = i;
        return {m_en, 11'b0, 5'(k)};
      end
      default: begin
        if (a >= 16 && a < 16 + NCH) begin
          k = a - 16;
          return {2'b0, m_wm[k], 6'(mq[k].size()), 2'b0, 1'(mq[k].size() == 4), 16'b0, m_en[k]};
        end
        return 0;
      end
    endcase
  endfunction

  task automatic check(bit ok, string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_update();
    bit [NCH-1:0] o_en = m_en, o_stop = m_stop, o_busy = m_busy, o_ad = m_ad;
    bit [31:0] os = m_src, od = m_dst, oz = m_size;
    bit [95:0] desc;
    int sz;
    bit psh, pp, cm;
    if (d_wr_en)
      case (d_wr_addr)
        0: m_src = d_wr_data;
        1: m_dst = d_wr_data;
        2: m_size = d_wr_data;
        5: m_tc &= ~d_wr_data[15:0];
        6: m_tc |= d_wr_data[15:0];
        8: m_pc &= ~d_wr_data[15:0];
        9: m_pc |= d_wr_data[15:0];
        11: m_lw &= ~d_wr_data[15:0];
        12: m_lw |= d_wr_data[15:0];
        13: m_ovf &= ~d_wr_data[15:0];
        default: ;
      endcase
    for (int i = 0; i < NCH; i++) begin
      sz = mq[i].size();
      psh = d_wr_en && d_wr_addr == 3 && d_wr_data < NCH && d_wr_data[3:0] == i;
      pp = d_pop_req && d_pop_ch == i && o_en[i] && !o_busy[i] && !o_stop[i] && sz > 0;
      cm = d_cmpl_vld && d_cmpl_ch == i && o_busy[i];
      if (o_stop[i] && !o_busy[i]) begin m_en[i] = 0; m_stop[i] = 0; end
      if (pp) begin
        desc = mq[i].pop_front();
        m_busy[i] = 1;
        m_ad[i] = desc[24];
        if (!(psh && sz < 4) && sz == 1) m_pc[i] = 1;
        if (!(psh && sz < 4) && m_wm[i] != 0 && sz == m_wm[i]) m_lw[i] = 1;
      end
      if (psh && sz < 4) mq[i].push_back({os, od, oz});
      if (psh && sz == 4) m_ovf[i] = 1;
      if (cm) begin
        m_busy[i] = 0;
        m_tc[i] = 1;
        if (o_ad[i]) begin m_en[i] = 0; m_stop[i] = 0; end
      end
      if (d_wr_en && d_wr_addr == 16 + i) begin
        m_wm[i] = d_wr_data[29:26];
        if (d_wr_data[0]) begin m_en[i] = 1; m_stop[i] = 0; end
        else if (o_en[i]) m_stop[i] = 1;
      end
    end
  endtask

  task automatic step();
    bit ev;
    #1;
    ev = d_pop_req && m_en[d_pop_ch] && !m_busy[d_pop_ch] && !m_stop[d_pop_ch] && mq[d_pop_ch].size() > 0;
    check(pop_vld === ev, "pop_vld", 96'(pop_vld), 96'(ev));
    if (ev) check({pop_src, pop_dst, pop_size} === mq[d_pop_ch][0], "pop data",
                  {pop_src, pop_dst, pop_size}, mq[d_pop_ch][0]);
    check(rd_data === m_read(d_rd_addr), "rd_data", 96'(rd_data), 96'(m_read(d_rd_addr)));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    d_wr_en = 1; d_wr_addr = a; d_wr_data = d; step(); d_wr_en = 0;
  endtask
  task automatic rd(logic [7:0] a);
    d_rd_addr = a; step();
  endtask
  task automatic pop(logic [3:0] c);
    d_pop_req = 1; d_pop_ch = c; step(); d_pop_req = 0;
  endtask
  task automatic cmpl(logic [3:0] c);
    d_cmpl_vld = 1; d_cmpl_ch = c; step(); d_cmpl_vld = 0;
  endtask
  task automatic push_desc(int c, logic [31:0] s, logic [31:0] d, logic [31:0] z);
    wr(0, s); wr(1, d); wr(2, z); wr(3, 32'(c));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R12"; rd(14); rd(16);            // reset state
    cur_req = "R2"; wr(16, 1); wr(17, (2 << 26) | 1); wr(19, (3 << 26) | 1); rd(17);
    cur_req = "R12"; rd(14);
    cur_req = "R1";
    for (int k = 0; k < 4; k++) push_desc(1, 32'h100 + k, 32'h200 + k, 32'h10 + k);
    cur_req = "R2"; rd(17);
    cur_req = "R3"; wr(0, 32'hABC); wr(3, 1); rd(13); rd(0);
    cur_req = "R4"; wr(3, 20); rd(17); rd(14 + 7);
    cur_req = "R9"; pop(1); pop(1);
    cur_req = "R7"; cmpl(1); cmpl(1); rd(4);
    cur_req = "R3"; wr(3, 1); rd(17);
    cur_req = "R5";
    for (int k = 0; k < 4; k++) begin pop(1); cmpl(1); rd(10); end
    cur_req = "R6"; pop(1); cmpl(1); rd(7); rd(17);
    cur_req = "R8"; wr(12, 32'hF0F0); rd(10); wr(11, 32'hFFFF); rd(10); wr(6, 32'h8); rd(4); wr(5, 32'hFFFF); rd(4);
    cur_req = "R11"; push_desc(0, 1, 2, 32'h0100_0040); pop(0); rd(16); cmpl(0); rd(16); rd(16); rd(14);
    cur_req = "R10"; push_desc(3, 5, 6, 7); push_desc(3, 8, 9, 10); pop(3);
    wr(19, 3 << 26); rd(19); rd(19); pop(3); cmpl(3); rd(19); rd(19); rd(19);
    cur_req = "R12";
    for (int k = 0; k < NCH; k++) wr(8'(16 + k), 1);
    rd(14);
    cur_req = "R8";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 16;
      d_wr_en = r < 10;
      case (r)
        0, 1, 2: begin d_wr_addr = 8'(r); d_wr_data = $urandom; if ($urandom % 4 != 0) d_wr_data[24] = 0; end
        3, 4, 5: begin d_wr_addr = 3; d_wr_data = $urandom % 18; end
        6: begin d_wr_addr = 8'(16 + $urandom % 16); d_wr_data = $urandom; d_wr_data[0] = ($urandom % 4 != 0); end
        7: begin d_wr_addr = 8'(5 + 3 * ($urandom % 3)); d_wr_data = $urandom; end
        8: begin d_wr_addr = 8'(6 + 3 * ($urandom % 3)); d_wr_data = $urandom & ($urandom); end
        9: begin d_wr_addr = 13; d_wr_data = $urandom; end
        default: ;
      endcase
      d_pop_req = $urandom % 2; d_pop_ch = 4'($urandom);
      d_cmpl_vld = ($urandom % 5) < 2; d_cmpl_ch = 4'($urandom);
      d_rd_addr = 8'($urandom % 32);
      step();
    end
    d_wr_en = 0; d_pop_req = 0; d_cmpl_vld = 0;
    done = 1;
    finish_run();
  end
endmodule